// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This block resolves every data-memory access of a small 8-bit core onto a register space of four banks, each 128 bytes wide. A 7-bit offset comes from the instruction. The bank is taken from two bits of a status register that the block holds itself. Offset 00h is a port: any access there is redirected through an 8-bit pointer register, with one extra status bit selecting the upper bank pair. For each access the block computes a canonical physical index and a flag that separates special-function registers from general-purpose storage. It returns read data combinationally and commits writes on the clock edge.

The low 32 offsets of every bank are reserved for special-function registers. Only the core ones are implemented as stubs: the port, the low byte of the program counter, the status register and the pointer. These four answer at the same offset in all banks. General-purpose RAM fills offsets 20h to 6Fh of banks 0 to 2. Offsets 70h to 7Fh form one 16-byte region that every bank shares. Together these make 256 bytes of storage. Everything else reads as zero and drops writes.

Top module: `regbank_addr_unit`

## Requirements
- R1: With status bits 6:5 equal to b, a direct access at offset o in 20h..6Fh gives phys_idx_o = b*128 + o, and a status write moves bank_o to the written bits 6:5 on the next cycle.
- R2: is_sfr_o is high exactly when the effective offset (after any redirection through the pointer) is below 20h.
- R3: Offsets 02h (program counter low byte), 03h (status) and 04h (pointer) reach the same register from every bank, and phys_idx_o equals the offset.
- R4: Offsets 70h..7Fh reach the same byte from every bank, and phys_idx_o equals the offset.
- R5: An access at offset 00h uses bank {status bit 7, pointer bit 7} and offset pointer bits 6:0. phys_idx_o, is_sfr_o and the data all follow that effective location.
- R6: When the redirected offset is itself 00h, the read returns zero and the write changes nothing.
- R7: Bank 3 offsets 20h..6Fh, and special offsets other than 00h, 02h, 03h and 04h, read zero and ignore writes.
- R8: Reset clears the status, pointer and program-counter-low registers, so bank_o is 0.
- R9: A byte written to an implemented general-purpose location reads back unchanged until it is next written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 7 | Offset within the bank, from the instruction |
| we_i | input | 1 | Write strobe, committed on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current access |
| phys_idx_o | output | 9 | Canonical physical index {bank, offset} |
| is_sfr_o | output | 1 | Effective location is a special-function register |
| bank_o | output | 2 | Current bank-select bits |

## Verification
Redirection through the pointer and bank switching can happen in the same cycle. This occurs when a write through port 00h lands on the status register, so the very access that is being redirected also changes the bank for the next one. The bench provokes this directly by aiming the pointer at 03h and 83h. It also reaches it at random by loading the pointer with arbitrary bytes between port accesses. A bench model resolves each access from its own copy of status and pointer, and judges every address, flag and data value against that model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int OFF_W  = 7;
  localparam int BANK_W = 2;
  localparam int DATA_W = 8;
  localparam int PHYS_W = OFF_W + BANK_W;

  localparam logic [OFF_W-1:0] GPR_BASE    = 7'h20;
  localparam logic [OFF_W-1:0] SHARED_BASE = 7'h70;
  localparam logic [OFF_W-1:0] OFF_PORT    = 7'h00;
  localparam logic [OFF_W-1:0] OFF_PCL     = 7'h02;
  localparam logic [OFF_W-1:0] OFF_STAT    = 7'h03;
  localparam logic [OFF_W-1:0] OFF_PTR     = 7'h04;

  localparam int GPR_PER_BANK = int'(SHARED_BASE) - int'(GPR_BASE);
  localparam int SHARED_SIZE  = (1 << OFF_W) - int'(SHARED_BASE);

  localparam int STAT_IND_BIT  = 7;
  localparam int STAT_BANK_LSB = 5;

  typedef enum logic [1:0] {CORE_NONE, CORE_PCL, CORE_STAT, CORE_PTR} core_sel_e;
endpackage

// File: rtl/regbank_addr_map.sv
module regbank_addr_map
  import regbank_pkg::*;
#(
  parameter int GPR_BANKS = 3,
  parameter int RAM_AW    = 8
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] ptr_i,
  input  logic              ind_bank_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_sfr_o,
  output core_sel_e         core_sel_o,
  output logic              ram_hit_o,
  output logic [RAM_AW-1:0] ram_idx_o,
  output logic              loop_o
);
  logic              ind;
  logic [BANK_W-1:0] eff_bank;
  logic [OFF_W-1:0]  eff_off;
  logic              sfr, shared, mirrored;

  always_comb begin
    ind      = (off_i == OFF_PORT);
    eff_bank = ind ? {ind_bank_i, ptr_i[DATA_W-1]} : bank_i;
    eff_off  = ind ? ptr_i[OFF_W-1:0] : off_i;
    loop_o   = ind && (eff_off == OFF_PORT);
    sfr      = (eff_off < GPR_BASE);
    shared   = (eff_off >= SHARED_BASE);

    unique case (eff_off)
      OFF_PCL:  core_sel_o = CORE_PCL;
      OFF_STAT: core_sel_o = CORE_STAT;
      OFF_PTR:  core_sel_o = CORE_PTR;
      default:  core_sel_o = CORE_NONE;
    endcase
    mirrored = (core_sel_o != CORE_NONE) || loop_o;

    phys_o    = (mirrored || shared) ? {{BANK_W{1'b0}}, eff_off} : {eff_bank, eff_off};
    is_sfr_o  = sfr;
    ram_hit_o = !sfr && (shared || (int'(eff_bank) < GPR_BANKS));

    if (shared)
      ram_idx_o = RAM_AW'(GPR_BANKS * GPR_PER_BANK) + RAM_AW'(eff_off - SHARED_BASE);
    else
      ram_idx_o = RAM_AW'(eff_bank) * RAM_AW'(GPR_PER_BANK) + RAM_AW'(eff_off - GPR_BASE);
  end
endmodule

// File: rtl/regbank_core_sfr.sv
module regbank_core_sfr
  import regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  core_sel_e         sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              ind_bank_o,
  output logic [DATA_W-1:0] ptr_o
);
  logic [DATA_W-1:0] pcl_q, stat_q, ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcl_q  <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        CORE_PCL:  pcl_q  <= wdata_i;
        CORE_STAT: stat_q <= wdata_i;
        CORE_PTR:  ptr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      CORE_PCL:  rdata_o = pcl_q;
      CORE_STAT: rdata_o = stat_q;
      CORE_PTR:  rdata_o = ptr_q;
      default:   rdata_o = '0;
    endcase
  end

  assign bank_o     = stat_q[STAT_BANK_LSB +: BANK_W];
  assign ind_bank_o = stat_q[STAT_IND_BIT];
  assign ptr_o      = ptr_q;

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (bank_o == '0 && !ind_bank_o && ptr_o == '0 && pcl_q == '0));

  assert_bank_follows_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CORE_STAT) |=> (bank_o == $past(wdata_i[STAT_BANK_LSB +: BANK_W])));
endmodule

// File: rtl/regbank_gpr_ram.sv
module regbank_gpr_ram
  import regbank_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(idx_i) < DEPTH) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = (int'(idx_i) < DEPTH) ? mem_q[idx_i] : '0;

  assert_readback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) < DEPTH) |=> ((idx_i != $past(idx_i)) || (rdata_o == $past(wdata_i))));
endmodule

// File: rtl/regbank_addr_unit.sv
module regbank_addr_unit
  import regbank_pkg::*;
#(
  parameter int GPR_BANKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PHYS_W-1:0] phys_idx_o,
  output logic              is_sfr_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam int RAM_DEPTH = GPR_BANKS * GPR_PER_BANK + SHARED_SIZE;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  logic [BANK_W-1:0] bank;
  logic              ind_bank, loop, ram_hit;
  logic [DATA_W-1:0] ptr, sfr_rd, ram_rd;
  logic [RAM_AW-1:0] ram_idx;
  core_sel_e         core_sel;

  regbank_addr_map #(.GPR_BANKS(GPR_BANKS), .RAM_AW(RAM_AW)) u_map (
    .off_i(addr_i), .bank_i(bank), .ptr_i(ptr), .ind_bank_i(ind_bank),
    .phys_o(phys_idx_o), .is_sfr_o(is_sfr_o), .core_sel_o(core_sel),
    .ram_hit_o(ram_hit), .ram_idx_o(ram_idx), .loop_o(loop)
  );

  regbank_core_sfr u_core (
    .clk_i, .rst_ni, .we_i(we_i && !loop), .sel_i(core_sel), .wdata_i,
    .rdata_o(sfr_rd), .bank_o(bank), .ind_bank_o(ind_bank), .ptr_o(ptr)
  );

  regbank_gpr_ram #(.DEPTH(RAM_DEPTH), .RAM_AW(RAM_AW)) u_ram (
    .clk_i, .rst_ni, .we_i(we_i && ram_hit), .idx_i(ram_idx), .wdata_i, .rdata_o(ram_rd)
  );

  always_comb begin
    if (loop)                       rdata_o = '0;
    else if (core_sel != CORE_NONE) rdata_o = sfr_rd;
    else if (ram_hit)               rdata_o = ram_rd;
    else                            rdata_o = '0;
  end

  assign bank_o = bank;

  assert_port_loop_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_PORT && ptr[OFF_W-1:0] == OFF_PORT) |-> (rdata_o == '0 && is_sfr_o));

  assert_shared_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= SHARED_BASE) |-> (phys_idx_o == {{BANK_W{1'b0}}, addr_i} && !is_sfr_o));

  assert_core_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_STAT) |-> (phys_idx_o == PHYS_W'(OFF_STAT) && rdata_o[STAT_BANK_LSB +: BANK_W] == bank_o));

  assert_direct_bank_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= GPR_BASE && addr_i < SHARED_BASE) |-> (phys_idx_o == {bank_o, addr_i}));
endmodule

// File: tb/regbank_addr_unit_bench.sv
module regbank_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [8:0] phys;
  logic       is_sfr;
  logic [1:0] bank;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_stat = '0, m_ptr = '0, m_pcl = '0;
  logic [7:0] m_ram [512];

  always #10 clk = ~clk;

  regbank_addr_unit u_regbank_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .phys_idx_o(phys), .is_sfr_o(is_sfr), .bank_o(bank)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  // kind: 0 port loop, 1 pcl, 2 status, 3 pointer, 4 ram, 5 unimplemented
  function automatic void resolve(input logic [6:0] a, output logic [8:0] p,
                                  output logic s, output int kind, output logic ind);
    logic [1:0] b;
    logic [6:0] o;
    ind = (a == 7'h00);
    b = ind ? {m_stat[7], m_ptr[7]} : m_stat[6:5];
    o = ind ? m_ptr[6:0] : a;
    s = (o < 7'h20);
    if (ind && o == 7'h00) begin kind = 0; p = 9'h000; end
    else if (o == 7'h02)   begin kind = 1; p = {2'b00, o}; end
    else if (o == 7'h03)   begin kind = 2; p = {2'b00, o}; end
    else if (o == 7'h04)   begin kind = 3; p = {2'b00, o}; end
    else if (s)            begin kind = 5; p = {b, o}; end
    else if (o >= 7'h70)   begin kind = 4; p = {2'b00, o}; end
    else if (b == 2'd3)    begin kind = 5; p = {b, o}; end
    else                   begin kind = 4; p = {b, o}; end
  endfunction

  task automatic op(input logic [6:0] a, input logic w, input logic [7:0] d);
    logic [8:0] p;
    logic       s, ind;
    int         kind;
    logic [7:0] exp;
    string      tag;
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #2;
    resolve(a, p, s, kind, ind);
    case (kind)
      0: begin exp = 8'h00;    tag = "R6"; end
      1: begin exp = m_pcl;    tag = "R3"; end
      2: begin exp = m_stat;   tag = "R3"; end
      3: begin exp = m_ptr;    tag = "R3"; end
      4: begin exp = m_ram[p]; tag = (p[6:0] >= 7'h70) ? "R4" : "R9"; end
      default: begin exp = 8'h00; tag = "R7"; end
    endcase
    check(tag, {1'b0, rdata}, {1'b0, exp});
    check(ind ? "R5" : "R1", phys, p);
    check("R2", {8'h00, is_sfr}, {8'h00, s});
    if (w) begin
      case (kind)
        1: m_pcl = d;
        2: m_stat = d;
        3: m_ptr = d;
        4: m_ram[p] = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] a;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #3;
    check("R8", {7'h0, bank}, 9'h0);
    rst_n = 1'b1;
    op(7'h03, 1'b0, 8'h00);  // R8 status reads zero
    op(7'h04, 1'b0, 8'h00);  // R8 pointer reads zero
    op(7'h02, 1'b0, 8'h00);  // R8 pc low reads zero

    // R1 R9 R4 R7: fill every bank
    for (int b = 0; b < 4; b++) begin
      op(7'h03, 1'b1, 8'(b << 5));
      @(negedge clk);
      check("R1", {7'h0, bank}, 9'(b));
      for (int o = 32; o < 128; o++) op(7'(o), 1'b1, 8'(o ^ (b * 37)));
    end
    for (int b = 0; b < 4; b++) begin
      op(7'h03, 1'b1, 8'(b << 5));
      for (int o = 32; o < 128; o += 7) op(7'(o), 1'b0, 8'h00);
      op(7'h02, 1'b1, 8'(8'hA0 + b));   // R3 same pc low from each bank
      op(7'h11, 1'b1, 8'hFF);           // R7 unimplemented special
      op(7'h11, 1'b0, 8'h00);
    end

    // R6 port through itself
    op(7'h04, 1'b1, 8'h00);
    op(7'h00, 1'b1, 8'h5A);
    op(7'h00, 1'b0, 8'h00);
    op(7'h04, 1'b1, 8'h80);
    op(7'h03, 1'b1, 8'h80);
    op(7'h00, 1'b1, 8'h33);
    op(7'h00, 1'b0, 8'h00);

    // R5 indirect onto status: redirection and bank switch together
    op(7'h03, 1'b1, 8'h00);
    op(7'h04, 1'b1, 8'h03);
    op(7'h00, 1'b1, 8'hC0);
    op(7'h45, 1'b0, 8'h00);
    op(7'h04, 1'b1, 8'h83);
    op(7'h00, 1'b1, 8'h20);
    op(7'h00, 1'b0, 8'h00);
    op(7'h04, 1'b1, 8'hC5);
    op(7'h00, 1'b1, 8'h77);
    op(7'h00, 1'b0, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(0, 5))
        0: a = 7'h00;
        1: a = 7'h03;
        2: a = 7'h04;
        3: a = 7'($urandom_range(0, 31));
        default: a = 7'($urandom_range(0, 127));
      endcase
      op(a, 1'($urandom_range(0, 1)), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule